// File: doc/BRIEF.md
# Synchronous Buck Gate Sequencer

This block turns a fixed-rate switching tick and a PWM comparator trip into the two gate commands of a synchronous buck power stage. Each switching tick ends the low-side conduction, waits a leading dead time with both switches off, then turns the high side on. The high side stays on until the comparator trips or a maximum on-count is reached, whichever comes first. A trip that comes before a minimum on-count is dropped. A trailing dead time follows, and then the low side conducts until the next tick. All timing is counted in ticks of the system clock (10 ns per tick is the intended use). The two dead times, the maximum on-count and the minimum on-count are parameters.

A kill input forces both gates off from the next clock edge. It holds them off while it is high. After it is released, the block waits for a fresh switching tick before it starts again. Each time the high side is turned off by a trip or by the clamp, the block reports the measured on-count with a one-cycle strobe.

The on-count report is a plain strobe with no ready. It is never held or repeated, so a consumer that cannot take it in that cycle loses it. The switching tick and the trip are one-cycle synchronous pulses. The integrator chooses MAX_ON so that DT_LH + MAX_ON + DT_HL fits inside one switching period. A tick that arrives before the sequence has returned to the low-side phase is dropped.

Top module: `buck_gate_seq`

## Requirements
- R1: After reset, `hs_gate`, `ls_gate` and `ton_valid` are low, and both gates stay low until the first `sw_tick`.
- R2: A `sw_tick` sampled while idle or in the low-side phase drops `ls_gate` at that edge. `hs_gate` rises exactly DT_LH cycles later, with both gates low in between.
- R3: A `pwm_trip` sampled while `hs_gate` has been high for at least MIN_ON cycles, counting the current cycle, drops `hs_gate` at that edge.
- R4: A `pwm_trip` sampled while `hs_gate` has been high for fewer than MIN_ON cycles is ignored and not remembered.
- R5: If no trip is accepted, `hs_gate` is forced low after exactly MAX_ON cycles high.
- R6: After `hs_gate` falls, both gates stay low for exactly DT_HL cycles. `ls_gate` then rises and stays high until the next `sw_tick` or kill.
- R7: `hs_gate` and `ls_gate` are never high in the same cycle.
- R8: A `sw_tick` sampled during the leading dead time, the high-side phase or the trailing dead time has no effect.
- R9: While `gate_kill` is sampled high, both gates are low from the next cycle on, no strobe is issued, and `sw_tick` is ignored. After release, both gates stay low until a `sw_tick` starts the R2 sequence.
- R10: In the cycle after `hs_gate` falls because of a trip or the clamp, `ton_valid` is high for exactly one cycle and `ton_count` equals the number of cycles `hs_gate` was high. A pulse ended by `gate_kill` gives no strobe.
- R11: A `pwm_trip` sampled outside the high-side phase has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one timing tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_tick | input | 1 | One-cycle pulse marking the start of a switching period |
| pwm_trip | input | 1 | One-cycle comparator trip pulse that ends the on-time |
| gate_kill | input | 1 | Forces both gates off while high |
| hs_gate | output | 1 | High-side gate command |
| ls_gate | output | 1 | Low-side gate command |
| ton_valid | output | 1 | One-cycle strobe qualifying `ton_count` |
| ton_count | output | CW | Measured high-side on-count (CW = $clog2(max(MAX_ON,DT_LH,DT_HL)+1)) |

## Verification
The bench places trips exactly one cycle before and at the minimum on-count. A design with an off-by-one threshold would either cut the pulse short or run it out to the clamp. It sends ticks inside each dead time and inside the high phase. A design that restarts on those ticks would shorten a dead time or produce a second high pulse. Kill is applied in the middle of a pulse, in the same cycle as a trip, and during the low phase, with a tick while the kill is held. A wrong design would report a stray on-count, resume without a fresh tick, or keep a gate on. A long pseudo-random run then compares dead-time lengths, clamp length and the reported counts against the model on every cycle.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_HIGH,
    PH_TRAIL,
    PH_LOW
  } phase_e;
endpackage

// File: rtl/bgs_tick_counter.sv
module bgs_tick_counter #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (~&cnt)   cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/bgs_phase_ctrl.sv
module bgs_phase_ctrl
  import bgs_pkg::*;
#(
  parameter int CW     = 7,
  parameter int DT_LH  = 9,
  parameter int DT_HL  = 8,
  parameter int MAX_ON = 80,
  parameter int MIN_ON = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_tick,
  input  logic          pwm_trip,
  input  logic          gate_kill,
  input  logic [CW-1:0] cnt,
  output phase_e        phase,
  output logic          cnt_clr,
  output logic          hs_end
);
  localparam logic [CW-1:0] LEAD_LAST  = CW'(DT_LH - 1);
  localparam logic [CW-1:0] TRAIL_LAST = CW'(DT_HL - 1);
  localparam logic [CW-1:0] ON_LAST    = CW'(MAX_ON - 1);
  localparam logic [CW-1:0] ON_FLOOR   = CW'(MIN_ON - 1);

  phase_e nxt;

  always_comb begin
    nxt    = phase;
    hs_end = 1'b0;
    if (gate_kill) begin
      nxt = PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE, PH_LOW: if (sw_tick) nxt = PH_LEAD;
        PH_LEAD:         if (cnt == LEAD_LAST) nxt = PH_HIGH;
        PH_HIGH: begin
          if ((cnt == ON_LAST) || (pwm_trip && (cnt >= ON_FLOOR))) begin
            nxt    = PH_TRAIL;
            hs_end = 1'b1;
          end
        end
        PH_TRAIL:        if (cnt == TRAIL_LAST) nxt = PH_LOW;
        default:         nxt = PH_IDLE;
      endcase
    end
  end

  assign cnt_clr = (nxt != phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end

  // R8: once the lead gap starts, a tick cannot restart it
  assert_lead_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LEAD && !gate_kill && cnt != LEAD_LAST) |=> (phase == PH_LEAD));
endmodule

// File: rtl/bgs_ton_report.sv
module bgs_ton_report #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_end,
  input  logic [CW-1:0] cnt,
  output logic          ton_valid,
  output logic [CW-1:0] ton_count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ton_valid <= 1'b0;
      ton_count <= '0;
    end else begin
      ton_valid <= hs_end;
      if (hs_end) ton_count <= cnt + CW'(1);
    end
  end

  // R10: the strobe never lasts two cycles
  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ton_valid |=> !ton_valid);
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
  import bgs_pkg::*;
#(
  parameter  int DT_LH  = 9,
  parameter  int DT_HL  = 8,
  parameter  int MAX_ON = 80,
  parameter  int MIN_ON = 7,
  localparam int TOP_A  = (MAX_ON > DT_LH) ? MAX_ON : DT_LH,
  localparam int TOP_B  = (TOP_A > DT_HL) ? TOP_A : DT_HL,
  localparam int CW     = $clog2(TOP_B + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_tick,
  input  logic          pwm_trip,
  input  logic          gate_kill,
  output logic          hs_gate,
  output logic          ls_gate,
  output logic          ton_valid,
  output logic [CW-1:0] ton_count
);
  localparam int CHK_W = CW + 1;

  phase_e        phase;
  logic [CW-1:0] cnt;
  logic          cnt_clr;
  logic          hs_end;

  bgs_tick_counter #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .cnt(cnt)
  );

  bgs_phase_ctrl #(
    .CW(CW), .DT_LH(DT_LH), .DT_HL(DT_HL), .MAX_ON(MAX_ON), .MIN_ON(MIN_ON)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_tick(sw_tick), .pwm_trip(pwm_trip),
    .gate_kill(gate_kill), .cnt(cnt), .phase(phase), .cnt_clr(cnt_clr),
    .hs_end(hs_end)
  );

  bgs_ton_report #(.CW(CW)) u_rpt (
    .clk(clk), .rst_n(rst_n), .hs_end(hs_end), .cnt(cnt),
    .ton_valid(ton_valid), .ton_count(ton_count)
  );

  assign hs_gate = (phase == PH_HIGH);
  assign ls_gate = (phase == PH_LOW);

  // Run-length trackers observed only by the checks below
  logic [CHK_W-1:0] gap_run, hs_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_run <= '0;
      hs_run  <= '0;
    end else begin
      if (hs_gate || ls_gate) gap_run <= '0;
      else if (~&gap_run)     gap_run <= gap_run + CHK_W'(1);
      if (!hs_gate)           hs_run  <= '0;
      else if (~&hs_run)      hs_run  <= hs_run + CHK_W'(1);
    end
  end

  assert_lead_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> (gap_run >= CHK_W'(DT_LH)));
  assert_trail_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> (gap_run >= CHK_W'(DT_HL)));
  assert_max_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hs_gate |-> (hs_run < CHK_W'(MAX_ON)));
  assert_min_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hs_gate) && !$past(gate_kill)) |-> (hs_run >= CHK_W'(MIN_ON)));
  assert_kill_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(gate_kill) |-> (!hs_gate && !ls_gate && !ton_valid));
  assert_strobe_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ton_valid |-> ($fell(hs_gate) && ({1'b0, ton_count} == hs_run)));
endmodule

// File: tb/buck_gate_seq_tb_top.sv
module buck_gate_seq_tb_top;
  localparam int DTLH = 9;
  localparam int DTHL = 8;
  localparam int MAXON = 80;
  localparam int MINON = 7;
  localparam int CW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_tick = 1'b0, pwm_trip = 1'b0, gate_kill = 1'b0;
  logic hs_gate, ls_gate, ton_valid;
  logic [CW-1:0] ton_count;

  always #2 clk = ~clk;

  buck_gate_seq #(.DT_LH(DTLH), .DT_HL(DTHL), .MAX_ON(MAXON), .MIN_ON(MINON)) dut_i (
    .clk(clk), .rst_n(rst_n), .sw_tick(sw_tick), .pwm_trip(pwm_trip),
    .gate_kill(gate_kill), .hs_gate(hs_gate), .ls_gate(ls_gate),
    .ton_valid(ton_valid), .ton_count(ton_count)
  );

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // Behavioural model: phase 0 idle, 1 lead gap, 2 high, 3 trail gap, 4 low
  int m_ph = 0, m_el = 0, m_rc = 0;
  bit m_rv = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_el = 0; m_rv = 1'b0;
    end else begin
      m_rv = 1'b0;
      if (gate_kill) begin
        m_ph = 0; m_el = 0;
      end else if (m_ph == 0 || m_ph == 4) begin
        if (sw_tick) begin m_ph = 1; m_el = 0; end
      end else if (m_ph == 1) begin
        m_el++;
        if (m_el == DTLH) begin m_ph = 2; m_el = 0; end
      end else if (m_ph == 2) begin
        m_el++;
        if ((pwm_trip && m_el >= MINON) || m_el == MAXON) begin
          m_rv = 1'b1; m_rc = m_el; m_ph = 3; m_el = 0;
        end
      end else begin
        m_el++;
        if (m_el == DTHL) begin m_ph = 4; m_el = 0; end
      end
    end
  end

  task automatic check_outs();
    bit eh, el;
    eh = (m_ph == 2);
    el = (m_ph == 4);
    vectors++;
    if (hs_gate !== eh || ls_gate !== el) begin
      miscompares++;
      $display("FAIL %s gates hs/ls actual=%0d/%0d expected=%0d/%0d t=%0t",
               cur_req, hs_gate, ls_gate, eh, el, $time);
    end
    vectors++;
    if (hs_gate === 1'b1 && ls_gate === 1'b1) begin
      miscompares++;
      $display("FAIL R7 overlap actual=11 expected=not both t=%0t", $time);
    end
    vectors++;
    if (ton_valid !== m_rv) begin
      miscompares++;
      $display("FAIL R10 ton_valid actual=%0d expected=%0d (%s) t=%0t",
               ton_valid, m_rv, cur_req, $time);
    end
    if (m_rv) begin
      vectors++;
      if (ton_count !== CW'(m_rc)) begin
        miscompares++;
        $display("FAIL R10 ton_count actual=%0d expected=%0d (%s) t=%0t",
                 ton_count, m_rc, cur_req, $time);
      end
    end
  endtask

  task automatic cyc(input bit sw, input bit tr, input bit kl);
    sw_tick = sw; pwm_trip = tr; gate_kill = kl;
    @(posedge clk);
    @(negedge clk);
    check_outs();
  endtask

  // One switching period; -1 disables an option
  task automatic period(input int trip_at, input int tick2_at,
                        input int kill_from, input int kill_to, input int len);
    for (int i = 0; i < len; i++)
      cyc((i == 0) || (i == tick2_at), (i == trip_at),
          (i >= kill_from) && (i < kill_to));
  endtask

  int lfsr = 32'h1ACE5;
  function automatic int nxt_rand();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h80200003 : 0);
    return lfsr & 32'h7FFF_FFFF;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    cur_req = "R1";
    vectors++;
    if (hs_gate !== 1'b0 || ls_gate !== 1'b0 || ton_valid !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 reset outputs actual=%0d%0d%0d expected=000", hs_gate, ls_gate, ton_valid);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) cyc(1'b0, (i == 5), 1'b0);   // idle, stray trip (R1/R11)
    cur_req = "R2";  period(-1, -1, -1, -1, 100);             // from idle; clamp ends it
    cur_req = "R5";  period(-1, -1, -1, -1, 100);             // clamp at MAX_ON
    cur_req = "R3";  period(DTLH + 30, -1, -1, -1, 100);      // trip mid-pulse
    cur_req = "R4";  period(DTLH + MINON - 1, -1, -1, -1, 100); // one short of floor: ignored
    cur_req = "R3";  period(DTLH + MINON, -1, -1, -1, 100);   // exactly at floor: accepted
    cur_req = "R11"; period(3, -1, -1, -1, 100);              // trip in lead gap
    cur_req = "R11"; period(99, -1, -1, -1, 100);             // trip in low phase
    cur_req = "R8";  period(-1, 4, -1, -1, 100);              // tick in lead gap
    cur_req = "R8";  period(-1, 50, -1, -1, 100);             // tick in high phase
    cur_req = "R8";  period(-1, 92, -1, -1, 100);             // tick in trail gap
    cur_req = "R6";  period(40, -1, -1, -1, 150);             // low side holds until tick
    cur_req = "R9";  period(-1, 40, 30, 45, 100);             // kill mid-pulse, tick while killed
    cur_req = "R9";  period(40, -1, 40, 41, 100);             // kill with trip in same cycle
    cur_req = "R9";  period(30, -1, 95, 99, 100);             // kill during low phase
    cur_req = "R10"; period(DTLH + 20, -1, -1, -1, 100);
    for (int p = 0; p < 40; p++) begin
      int ta, ka;
      ta = nxt_rand() % 100;
      ka = ((nxt_rand() % 8) == 0) ? (nxt_rand() % 100) : -1;
      cur_req = "R10";
      period(ta, ((nxt_rand() % 4) == 0) ? (nxt_rand() % 100) : -1,
             ka, (ka < 0) ? -1 : ka + 1 + (nxt_rand() % 6), 100);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule